// File: doc/BRIEF.md
# Predicated Vector Element Loop Sequencer

This block walks a vector loop of length VL one element at a time and uses predicate masks to choose which elements run. It keeps two counters: a source step and a destination step. Each runs over its own working copy of a mask. A dedicated skip cycle moves each counter past any run of clear mask bits in a single move. The next enabled element pair is then offered downstream on a valid/ready issue port.

The loop can start from any preset pair of steps, so an interrupted loop can be resumed. Mask bits below each starting step are discarded when the masks are captured. In single predication the source mask governs both counters. In twin predication the two masks are independent, which allows gather-style (compress) and scatter-style (expand) patterns. A mode input replaces each mask with a single set bit, chosen by an index operand.

The block reports two kinds of event:
- Each accepted element produces a one-cycle completion pulse.
- Each finished loop produces a one-cycle end pulse, even when nothing was issued.

Back-pressure: the issue port holds its valid and both step values until ready is seen. The steps move only on a completed handshake. The block never withdraws an offer.

Top module: `pred_elem_seq`

## Requirements
- R1: A synchronous reset puts the sequencer into idle: busy low, issue valid low, both steps 0, and no done or end pulse.
- R2: The start strobe is acted on only while idle. While busy, start and every mask, length, mode and step input are ignored, because all loop operands are captured at the accepted start.
- R3: After start, and after every accepted element, one skip cycle moves each step to the next set bit of its effective mask, at or above the current step. Every issued pair therefore has its source mask bit and destination mask bit set, and both steps are below VL while valid is high.
- R4: Issue valid stays high, with both steps unchanged, until ready is sampled high. On a handshake, the source step increments by one and the sequencer goes back to a skip cycle.
- R5: The element-done output is high for exactly the one cycle that follows each issue handshake.
- R6: A skip cycle ends the loop in any of these cases:
  - either step is already at or above VL;
  - the destination counter is saturated;
  - either next set bit would be at or above VL.
  
  When the loop ends, the end pulse is high for one cycle, the sequencer is idle in that cycle, and both steps keep their values. The end pulse may follow an element-done pulse on the very next cycle. A VL input above 64 acts as 64.
- R7: The destination step never reaches VL. An accepted element whose destination step is VL-1 leaves that step unchanged and makes the next skip cycle end the loop.
- R8: When no enabled element remains (for example, an all-zero mask or VL equal to 0), the loop ends with an end pulse and issues nothing.
- R9: When bit mode is 1, each effective mask is only bit `bit_idx_i` (0 to 63) set, and all other bits are clear. When bit mode is 0, the mask inputs are used as given.
- R10: Source and destination steps start at preset values. Mask bits below the preset are never used, and a preset pointing at a clear bit advances to the next set bit.
- R11: When twin is 0, the source mask and source preset govern both steps, `dst_mask_i` and `dst_init_i` are ignored, and the two steps are equal while valid is high.
- R12: When twin is 1, the source and destination steps follow their own masks and presets independently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Start strobe, acted on only while idle |
| twin_i | input | 1 | 1: twin predication, 0: single predication |
| bit_mode_i | input | 1 | 1: each mask becomes the single bit `bit_idx_i` |
| bit_idx_i | input | 6 | Bit index used in bit mode |
| vl_i | input | 7 | Vector length (values above 64 act as 64) |
| src_mask_i | input | 64 | Source predicate mask, bit n enables element n |
| dst_mask_i | input | 64 | Destination predicate mask (used only when twin is 1) |
| src_init_i | input | 7 | Preset source step |
| dst_init_i | input | 7 | Preset destination step (used only when twin is 1) |
| issue_valid_o | output | 1 | Element pair offered |
| issue_ready_i | input | 1 | Downstream accepts the offered pair |
| src_step_o | output | 7 | Current source step |
| dst_step_o | output | 7 | Current destination step |
| elem_done_o | output | 1 | One-cycle pulse after each accepted element |
| loop_end_o | output | 1 | One-cycle pulse when the loop finishes |
| busy_o | output | 1 | High while a loop is in progress |

## Verification
The following properties are checked on every cycle:
- the issue port holds valid and both steps while stalled;
- both steps are below VL whenever valid is high;
- the destination step never moves to VL or beyond;
- the done pulse follows each handshake;
- the end pulse is a single idle-cycle event that never coincides with done;
- the two steps are equal in single predication.

Other behaviour can only be shown by the bench's scenarios, compared cycle by cycle against an absolute-index model:
- which elements the skip logic chooses for sparse, compress and expand masks;
- that operands are ignored while busy;
- that resumed presets behave as required;
- that bit mode selects the right element;
- that all-zero masks and a VL of 0 or above 64 end the loop correctly;
- that done and end pulses can fall on consecutive cycles.

// File: rtl/pseq_pkg.sv
package pseq_pkg;
  localparam int unsigned MASK_W = 64;
  localparam int unsigned STEP_W = 7;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SKIP  = 2'd1,
    ST_ISSUE = 2'd2
  } seq_state_e;
endpackage

// File: rtl/pseq_tzc.sv
// Trailing-zero counter: index of the lowest set bit, or W when none is set.
module pseq_tzc #(
  parameter int unsigned W  = 64,
  parameter int unsigned CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  vec_i,
  output logic [CW-1:0] cnt_o
);
  always_comb begin
    cnt_o = CW'(W);
    for (int i = W - 1; i >= 0; i--) begin
      if (vec_i[i]) cnt_o = CW'(i);
    end
  end
endmodule

// File: rtl/pseq_mask_prep.sv
// Builds the effective mask (full or single-bit) and drops bits below the preset step.
module pseq_mask_prep #(
  parameter int unsigned W  = 64,
  parameter int unsigned SW = 7,
  localparam int unsigned IW = $clog2(W)
) (
  input  logic [W-1:0]  mask_i,
  input  logic          bit_mode_i,
  input  logic [IW-1:0] bit_idx_i,
  input  logic [SW-1:0] shift_i,
  output logic [W-1:0]  mask_o
);
  logic [W-1:0] eff;

  always_comb begin
    eff    = bit_mode_i ? ({{(W-1){1'b0}}, 1'b1} << bit_idx_i) : mask_i;
    mask_o = eff >> shift_i;
  end
endmodule

// File: rtl/pred_elem_seq.sv
module pred_elem_seq
  import pseq_pkg::*;
#(
  parameter int unsigned W  = pseq_pkg::MASK_W,
  parameter int unsigned SW = pseq_pkg::STEP_W,
  localparam int unsigned IW = $clog2(W),
  localparam int unsigned CW = $clog2(W + 1),
  localparam int unsigned LANES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_i,
  input  logic          twin_i,
  input  logic          bit_mode_i,
  input  logic [IW-1:0] bit_idx_i,
  input  logic [SW-1:0] vl_i,
  input  logic [W-1:0]  src_mask_i,
  input  logic [W-1:0]  dst_mask_i,
  input  logic [SW-1:0] src_init_i,
  input  logic [SW-1:0] dst_init_i,
  output logic          issue_valid_o,
  input  logic          issue_ready_i,
  output logic [SW-1:0] src_step_o,
  output logic [SW-1:0] dst_step_o,
  output logic          elem_done_o,
  output logic          loop_end_o,
  output logic          busy_o
);
  seq_state_e state_q;
  logic [SW-1:0] vl_q;
  logic          twin_q;
  logic          dfull_q;
  logic          elem_done_q;
  logic          loop_end_q;
  logic [W-1:0]  wmask_q [LANES];
  logic [SW-1:0] step_q  [LANES];

  logic [W-1:0]  lane_mask [LANES];
  logic [SW-1:0] lane_init [LANES];
  logic [W-1:0]  prep_mask [LANES];
  logic [CW-1:0] tz        [LANES];
  logic [SW:0]   nxt       [LANES];
  logic [SW-1:0] vl_eff;
  logic          skip_end;
  logic [SW:0]   dst_inc;

  // Lane 0 = source, lane 1 = destination (mirrors source in single predication)
  assign lane_mask[0] = src_mask_i;
  assign lane_init[0] = src_init_i;
  assign lane_mask[1] = twin_i ? dst_mask_i : src_mask_i;
  assign lane_init[1] = twin_i ? dst_init_i : src_init_i;

  generate
    for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
      pseq_mask_prep #(.W(W), .SW(SW)) u_prep (
        .mask_i     (lane_mask[ln]),
        .bit_mode_i (bit_mode_i),
        .bit_idx_i  (bit_idx_i),
        .shift_i    (lane_init[ln]),
        .mask_o     (prep_mask[ln])
      );
      pseq_tzc #(.W(W), .CW(CW)) u_tzc (
        .vec_i (wmask_q[ln]),
        .cnt_o (tz[ln])
      );
      assign nxt[ln] = {1'b0, step_q[ln]} + (SW+1)'(tz[ln]);
    end
  endgenerate

  assign vl_eff  = (vl_i > SW'(W)) ? SW'(W) : vl_i;
  assign dst_inc = {1'b0, step_q[1]} + 1'b1;

  always_comb begin
    skip_end = dfull_q || (step_q[0] >= vl_q) || (step_q[1] >= vl_q);
    for (int ln = 0; ln < LANES; ln++) begin
      if (nxt[ln] >= {1'b0, vl_q}) skip_end = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      vl_q        <= '0;
      twin_q      <= 1'b0;
      dfull_q     <= 1'b0;
      elem_done_q <= 1'b0;
      loop_end_q  <= 1'b0;
      for (int ln = 0; ln < LANES; ln++) begin
        wmask_q[ln] <= '0;
        step_q[ln]  <= '0;
      end
    end else begin
      elem_done_q <= 1'b0;
      loop_end_q  <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            vl_q    <= vl_eff;
            twin_q  <= twin_i;
            dfull_q <= 1'b0;
            for (int ln = 0; ln < LANES; ln++) begin
              wmask_q[ln] <= prep_mask[ln];
              step_q[ln]  <= lane_init[ln];
            end
            state_q <= ST_SKIP;
          end
        end
        ST_SKIP: begin
          if (skip_end) begin
            loop_end_q <= 1'b1;
            state_q    <= ST_IDLE;
          end else begin
            for (int ln = 0; ln < LANES; ln++) begin
              step_q[ln]  <= nxt[ln][SW-1:0];
              wmask_q[ln] <= wmask_q[ln] >> tz[ln];
            end
            state_q <= ST_ISSUE;
          end
        end
        ST_ISSUE: begin
          if (issue_ready_i) begin
            elem_done_q <= 1'b1;
            step_q[0]   <= step_q[0] + 1'b1;
            wmask_q[0]  <= wmask_q[0] >> 1;
            if (dst_inc < {1'b0, vl_q}) begin
              step_q[1]  <= dst_inc[SW-1:0];
              wmask_q[1] <= wmask_q[1] >> 1;
            end else begin
              dfull_q <= 1'b1;
            end
            state_q <= ST_SKIP;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign issue_valid_o = (state_q == ST_ISSUE);
  assign busy_o        = (state_q != ST_IDLE);
  assign src_step_o    = step_q[0];
  assign dst_step_o    = step_q[1];
  assign elem_done_o   = elem_done_q;
  assign loop_end_o    = loop_end_q;
endmodule

// File: rtl/pseq_chk.sv
module pseq_chk #(
  parameter int unsigned SW = 7
) (
  input logic          clk,
  input logic          rst,
  input logic          issue_valid_o,
  input logic          issue_ready_i,
  input logic [SW-1:0] src_step_o,
  input logic [SW-1:0] dst_step_o,
  input logic          elem_done_o,
  input logic          loop_end_o,
  input logic          busy_o,
  input logic [SW-1:0] vl_q,
  input logic          twin_q
);
  assert_offer_hold_R4: assert property (@(posedge clk) disable iff (rst)
    issue_valid_o && !issue_ready_i |=> issue_valid_o && $stable(src_step_o) && $stable(dst_step_o));

  assert_issue_in_range_R3: assert property (@(posedge clk) disable iff (rst)
    issue_valid_o |-> (src_step_o < vl_q) && (dst_step_o < vl_q));

  assert_dst_cap_R7: assert property (@(posedge clk) disable iff (rst)
    busy_o && $past(busy_o) && !$stable(dst_step_o) |-> dst_step_o < vl_q);

  assert_done_after_hs_R5: assert property (@(posedge clk) disable iff (rst)
    issue_valid_o && issue_ready_i |=> elem_done_o);

  assert_end_idle_R6: assert property (@(posedge clk) disable iff (rst)
    loop_end_o |-> !busy_o && !issue_valid_o);

  assert_end_single_R6: assert property (@(posedge clk) disable iff (rst)
    loop_end_o |=> !loop_end_o);

  assert_pulse_excl_R6: assert property (@(posedge clk) disable iff (rst)
    $onehot0({elem_done_o, loop_end_o}));

  assert_single_equal_R11: assert property (@(posedge clk) disable iff (rst)
    issue_valid_o && !twin_q |-> src_step_o == dst_step_o);
endmodule

bind pred_elem_seq pseq_chk #(.SW(SW)) u_pseq_chk (
  .clk           (clk),
  .rst           (rst),
  .issue_valid_o (issue_valid_o),
  .issue_ready_i (issue_ready_i),
  .src_step_o    (src_step_o),
  .dst_step_o    (dst_step_o),
  .elem_done_o   (elem_done_o),
  .loop_end_o    (loop_end_o),
  .busy_o        (busy_o),
  .vl_q          (vl_q),
  .twin_q        (twin_q)
);

// File: tb/test_pred_elem_seq.sv
module test_pred_elem_seq;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic        start_i, twin_i, bit_mode_i, issue_ready_i;
  logic [5:0]  bit_idx_i;
  logic [6:0]  vl_i, src_init_i, dst_init_i;
  logic [63:0] src_mask_i, dst_mask_i;
  logic        issue_valid_o, elem_done_o, loop_end_o, busy_o;
  logic [6:0]  src_step_o, dst_step_o;

  int total = 0, bad = 0, cyc = 0, issues = 0, b2b = 0, ready_pat = 0;
  bit prev_ed = 0, ended = 0;
  int end_s = 0, end_d = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pred_elem_seq i_pred_elem_seq (
    .clk(clk), .rst(rst), .start_i(start_i), .twin_i(twin_i),
    .bit_mode_i(bit_mode_i), .bit_idx_i(bit_idx_i), .vl_i(vl_i),
    .src_mask_i(src_mask_i), .dst_mask_i(dst_mask_i),
    .src_init_i(src_init_i), .dst_init_i(dst_init_i),
    .issue_valid_o(issue_valid_o), .issue_ready_i(issue_ready_i),
    .src_step_o(src_step_o), .dst_step_o(dst_step_o),
    .elem_done_o(elem_done_o), .loop_end_o(loop_end_o), .busy_o(busy_o)
  );

  // Behavioural reference: absolute element indices, searched upward
  int m_ph = 0, m_s = 0, m_d = 0, m_vl = 0;
  bit m_twin = 0, m_dend = 0, m_ed = 0, m_le = 0;
  logic [63:0] m_sm = '0, m_dm = '0;

  function automatic int next_set(logic [63:0] m, int from);
    for (int j = from; j < 64; j++) if (m[j]) return j;
    return 200;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_ph = 0; m_s = 0; m_d = 0; m_vl = 0; m_dend = 0; m_ed = 0; m_le = 0;
    end else begin
      m_ed = 0; m_le = 0;
      if (m_ph == 0) begin
        if (start_i) begin
          m_vl = (int'(vl_i) > 64) ? 64 : int'(vl_i);
          m_twin = twin_i;
          m_sm = bit_mode_i ? (64'd1 << bit_idx_i) : src_mask_i;
          m_dm = !twin_i ? m_sm : (bit_mode_i ? (64'd1 << bit_idx_i) : dst_mask_i);
          m_s = int'(src_init_i);
          m_d = twin_i ? int'(dst_init_i) : int'(src_init_i);
          m_dend = 0; m_ph = 1;
        end
      end else if (m_ph == 1) begin
        int ns, nd;
        ns = next_set(m_sm, m_s);
        nd = next_set(m_dm, m_d);
        if (m_s >= m_vl || m_d >= m_vl || m_dend || ns >= m_vl || nd >= m_vl) begin
          m_le = 1; m_ph = 0;
        end else begin
          m_s = ns; m_d = nd; m_ph = 2;
        end
      end else begin
        if (issue_ready_i) begin
          m_ed = 1; m_s = m_s + 1;
          if (m_d + 1 < m_vl) m_d = m_d + 1; else m_dend = 1;
          m_ph = 1;
        end
      end
    end
  end

  task automatic chk(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // One cycle: compare at negedge, then drive ready for the coming edge
  task automatic tick();
    @(negedge clk);
    cyc++;
    chk(busy_o == (m_ph != 0), "R2 busy", int'(busy_o), int'(m_ph != 0));
    chk(issue_valid_o == (m_ph == 2), "R4 valid", int'(issue_valid_o), int'(m_ph == 2));
    chk(int'(src_step_o) == m_s, "R3 src_step", int'(src_step_o), m_s);
    chk(int'(dst_step_o) == m_d, "R12 dst_step", int'(dst_step_o), m_d);
    chk(elem_done_o == m_ed, "R5 elem_done", int'(elem_done_o), int'(m_ed));
    chk(loop_end_o == m_le, "R6 loop_end", int'(loop_end_o), int'(m_le));
    if (loop_end_o) begin
      ended = 1; end_s = int'(src_step_o); end_d = int'(dst_step_o);
      if (prev_ed) b2b++;
    end
    prev_ed = elem_done_o;
    case (ready_pat)
      0: issue_ready_i = 1'b1;
      1: issue_ready_i = (cyc % 3 == 0);
      default: issue_ready_i = ((cyc % 5) != 2) && ((cyc % 7) != 0);
    endcase
    if (issue_valid_o && issue_ready_i) issues++;
  endtask

  task automatic run(bit tw, bit bm, int idx, int vl, logic [63:0] sm, logic [63:0] dm,
                     int si, int di, int rp, bit poke, int exp_n, int exp_s, int exp_d,
                     string req);
    int n0;
    twin_i = tw; bit_mode_i = bm; bit_idx_i = 6'(idx); vl_i = 7'(vl);
    src_mask_i = sm; dst_mask_i = dm; src_init_i = 7'(si); dst_init_i = 7'(di);
    ready_pat = rp; ended = 0; n0 = issues;
    start_i = 1'b1;
    tick();
    start_i = 1'b0;
    for (int k = 0; k < 600 && !ended; k++) begin
      if (poke && k == 3) begin
        start_i = 1'b1; src_mask_i = ~sm; vl_i = 7'd3; src_init_i = 7'd1;
      end else if (poke && k == 4) begin
        start_i = 1'b0; src_mask_i = sm;
      end
      tick();
    end
    chk(ended, {req, " loop ended"}, int'(ended), 1);
    chk(issues - n0 == exp_n, {req, " issue count"}, issues - n0, exp_n);
    chk(end_s == exp_s, {req, " final src step"}, end_s, exp_s);
    chk(end_d == exp_d, {req, " final dst step"}, end_d, exp_d);
    tick();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst = 1'b1; start_i = 0; twin_i = 0; bit_mode_i = 0; bit_idx_i = 0; vl_i = 0;
    src_mask_i = 0; dst_mask_i = 0; src_init_i = 0; dst_init_i = 0; issue_ready_i = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    chk(!busy_o && !issue_valid_o && !elem_done_o && !loop_end_o, "R1 idle after reset",
        int'(busy_o), 0);
    chk(src_step_o == 0 && dst_step_o == 0, "R1 steps zero", int'(src_step_o), 0);
    tick();
    // R3/R6: sparse single mask, bits 2,4,5,7,9
    b2b = 0;
    run(0, 0, 0, 10, 64'h2B4, 64'hFFFF, 0, 0, 0, 0, 5, 10, 9, "R3");
    chk(b2b > 0, "R6 back-to-back done/end", b2b, 1);
    // R4: same with throttled ready
    run(0, 0, 0, 10, 64'h2B4, 64'h0, 0, 0, 1, 0, 5, 10, 9, "R4");
    // R8: all-zero mask, and VL of 0
    run(0, 0, 0, 16, 64'h0, 64'h0, 0, 0, 0, 0, 0, 0, 0, "R8 zero mask");
    run(0, 0, 0, 0, 64'hFF, 64'hFF, 0, 0, 0, 0, 0, 0, 0, "R8 vl zero");
    // R9: single-bit mode selects bit 5 only
    run(0, 1, 5, 8, 64'hFFFF, 64'h0, 0, 0, 0, 0, 1, 6, 6, "R9");
    // R10: resume at 6 over a clear bit; bit 3 is below the preset
    run(0, 0, 0, 12, 64'h208, 64'h0, 6, 0, 0, 0, 1, 10, 10, "R10");
    // R11: single predication ignores dst mask and dst preset
    run(0, 0, 0, 6, 64'h3C, 64'h0, 0, 5, 1, 0, 4, 6, 5, "R11");
    // R12: compress and expand patterns
    run(1, 0, 0, 5, 64'h16, 64'hFFFF, 0, 0, 0, 0, 3, 5, 3, "R12 compress");
    run(1, 0, 0, 5, 64'hFFFF, 64'h15, 0, 0, 2, 0, 3, 3, 4, "R7 expand");
    // R2: start and operands changed while busy are ignored
    run(0, 0, 0, 20, 64'hFFFFF, 64'h0, 0, 0, 2, 1, 20, 20, 19, "R2");
    // R7: full length twin loop, dst saturates at 63
    run(1, 0, 0, 64, '1, '1, 0, 0, 2, 0, 64, 64, 63, "R7 full");
    // R6: VL above 64 acts as 64
    run(0, 0, 0, 100, '1, 64'h0, 60, 0, 0, 0, 4, 64, 63, "R6 vl clamp");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule